// File: doc/BRIEF.md
# Converter Result Sequencer

This block paces the digital core of an oversampling converter. It holds the 24-bit setup word. It tracks whether the core is calibrating or converting. It moves each finished filter result into an output holding register and signals that result to the host through an active-low ready flag. The filter arithmetic, the calibration maths and the serial shifter are outside the block. They appear only as simple strobes: `res_valid` when a filter word is finished, `cal_finish` when a calibration has completed, and `host_reading` while the host is shifting the held word out.

Host writes carry byte enables. If a write touches either of the two upper bytes of the setup word, it counts as a critical change: the ready flag is withdrawn, a one-cycle restart pulse goes to the filter, and the core recalibrates if the new mode field asks for calibration. A write that changes only the lowest byte changes nothing else. A shared `sync_in` strobe realigns the filter timing of several devices that share one clock, so that they all present their next results together. While the host is reading a held word, a newly finished result is thrown away rather than written over the word being read.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset the setup word reads 28B300h, `rdy_n` is 1 and `cal_busy` is 1. The mode field is bits 23:21 of the setup word, and `cal_kind` shows it.
- R2: While `cal_busy` is 1, `res_valid` has no effect: `res_word` keeps its value and `rdy_n` stays 1.
- R3: `cal_finish` while calibrating clears `cal_busy` on the next cycle. From then on, each `res_valid` loads `res_in` into `res_word` and drives `rdy_n` to 0 on the following cycle.
- R4: `rdy_n` falls only in the cycle after an accepted `res_valid`.
- R5: A write whose byte enables include bit 2 or bit 1 (byte 2 = bits 23:16, byte 1 = bits 15:8) drives `rdy_n` to 1 and `restart` to 1 for exactly the next cycle.
- R6: After such a critical write, `cal_busy` is 1 if the resulting mode field is non-zero and 0 if it is 3'b000.
- R7: A write with enables 3'b001 updates only bits 7:0 of the setup word. `rdy_n`, `res_word`, `restart` and `cal_busy` stay as they were.
- R8: If `res_valid` arrives while `host_reading` is 1 and `rdy_n` is 0, the new result is discarded: `res_word` is unchanged and `rdy_n` stays 0.
- R9: After a discard, `rdy_n` returns to 1 in the cycle after `host_reading` falls. The next result loads as usual.
- R10: `sync_in` drives `restart` to 1 and `rdy_n` to 1 on the next cycle, and drops any result offered in the same cycle. It neither starts nor ends a calibration.
- R11: When several events fall in one cycle, a critical write takes priority over `sync_in`, and `sync_in` takes priority over a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Setup-word write strobe |
| wr_be | input | 3 | Byte enables of the write, bit n selects byte n |
| wr_data | input | 24 | Write data |
| sync_in | input | 1 | Shared timing realignment strobe |
| cal_finish | input | 1 | Calibration engine reports completion |
| res_valid | input | 1 | Filter result finished |
| res_in | input | 24 | Filter result word |
| host_reading | input | 1 | Host is shifting out the held word |
| cfg_word | output | 24 | Current setup word |
| cal_busy | output | 1 | Calibration requested or in progress |
| cal_kind | output | 3 | Mode field handed to the calibration engine |
| restart | output | 1 | One-cycle filter restart pulse |
| res_word | output | 24 | Held output word |
| rdy_n | output | 1 | Active-low result-ready flag |

## Verification
The assertions check on every cycle that the ready flag falls only after an accepted result and that the held word stays fixed during a protected read. They also check that critical writes and sync strobes withdraw the ready flag and pulse the restart, that a low-byte write leaves the upper bytes untouched, and that a critical write picks calibration from the mode field. Only the bench scenarios can show the full sequences: the path from reset through calibration to the first result, a discard followed by the ready flag rising after the read ends, a sync strobe arriving during calibration, and the value the held word keeps across mixed runs of read and no-read results.

// File: rtl/adc_seq_pkg.sv
// Shared constants and types for the converter result sequencer.
// Assumes an 8-bit byte lane granularity for the setup word.
package adc_seq_pkg;
    localparam int unsigned CFG_BYTES = 3;
    localparam int unsigned CFG_W     = CFG_BYTES * 8;
    localparam logic [CFG_W-1:0] CFG_RESET = 24'h28B300;
    localparam int unsigned MODE_LSB  = 21;
    localparam int unsigned MODE_W    = 3;
    localparam logic [CFG_BYTES-1:0] CRIT_BYTES = 3'b110;

    typedef enum logic {
        PH_CAL = 1'b0,
        PH_RUN = 1'b1
    } phase_t;
endpackage

// File: rtl/seq_cfg_reg.sv
// Setup-word register with byte-enabled writes.
// Flags a write as critical when it touches any byte marked in CRIT_MASK.
// Also presents the merged value so that a decision can be made on the new mode.
module seq_cfg_reg #(
    parameter int unsigned        NBYTES    = 3,
    parameter logic [NBYTES*8-1:0] RESET_VAL = '0,
    parameter logic [NBYTES-1:0]  CRIT_MASK = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NBYTES-1:0]   wr_be,
    input  logic [NBYTES*8-1:0] wr_data,
    output logic [NBYTES*8-1:0] cfg_q,
    output logic [NBYTES*8-1:0] cfg_next,
    output logic                crit_wr
);
    localparam int unsigned W = NBYTES * 8;

    // Merge each enabled byte lane over the stored value.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign cfg_next[b*8 +: 8] = (wr_en && wr_be[b]) ? wr_data[b*8 +: 8]
                                                         : cfg_q[b*8 +: 8];
    end

    // A write is critical when it reaches any protected byte lane.
    assign crit_wr = wr_en && |(wr_be & CRIT_MASK);

    // Store the merged setup word.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= RESET_VAL;
        else        cfg_q <= cfg_next[W-1:0];
    end
endmodule

// File: rtl/seq_phase_ctl.sv
// Calibration/conversion phase controller.
// Leaves reset in the calibration phase. A critical write re-enters calibration
// when the new mode field is non-zero. Critical writes and sync strobes emit
// a one-cycle restart. Assumes cal_done is a single-cycle strobe.
module seq_phase_ctl
    import adc_seq_pkg::*;
#(
    parameter int unsigned MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crit_wr,
    input  logic [MW-1:0] next_mode,
    input  logic          sync_in,
    input  logic          cal_done,
    output logic          cal_req,
    output logic          restart,
    output logic          accept
);
    phase_t phase;

    // Phase transitions and restart pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CAL;
            restart <= 1'b0;
        end else begin
            restart <= crit_wr || sync_in;
            if (crit_wr)
                phase <= (next_mode != '0) ? PH_CAL : PH_RUN;
            else if (phase == PH_CAL && cal_done)
                phase <= PH_RUN;
        end
    end

    // Results are only taken while converting and not being realigned.
    always_comb begin
        cal_req = (phase == PH_CAL);
        accept  = (phase == PH_RUN) && !crit_wr && !sync_in;
    end
endmodule

// File: rtl/seq_out_guard.sv
// Output holding register and active-low ready flag.
// While the host reads a valid word, new results are dropped. After such a
// drop the flag is withdrawn once the read ends. A flush withdraws it at once.
module seq_out_guard #(
    parameter int unsigned DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word_in,
    input  logic          reading,
    input  logic          flush,
    output logic [DW-1:0] word_q,
    output logic          rdy_n
);
    logic dropped;
    logic guarded;

    // The held word is protected while it is valid and being read.
    assign guarded = reading && !rdy_n;

    // Update the held word, the ready flag and the drop marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            rdy_n   <= 1'b1;
            dropped <= 1'b0;
        end else if (flush) begin
            rdy_n   <= 1'b1;
            dropped <= 1'b0;
        end else if (load && guarded) begin
            dropped <= 1'b1;
        end else if (load) begin
            word_q  <= word_in;
            rdy_n   <= 1'b0;
            dropped <= 1'b0;
        end else if (dropped && !reading) begin
            rdy_n   <= 1'b1;
            dropped <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_conv_sequencer.sv
// Top of the converter result sequencer: setup register, phase control and
// output guard. All outputs are registered or decoded from registers.
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_BYTES-1:0] wr_be,
    input  logic [CFG_W-1:0]     wr_data,
    input  logic                 sync_in,
    input  logic                 cal_finish,
    input  logic                 res_valid,
    input  logic [DATA_W-1:0]    res_in,
    input  logic                 host_reading,
    output logic [CFG_W-1:0]     cfg_word,
    output logic                 cal_busy,
    output logic [MODE_W-1:0]    cal_kind,
    output logic                 restart,
    output logic [DATA_W-1:0]    res_word,
    output logic                 rdy_n
);
    logic [CFG_W-1:0] cfg_next;
    logic             crit_wr;
    logic             accept;

    seq_cfg_reg #(
        .NBYTES   (CFG_BYTES),
        .RESET_VAL(CFG_RESET),
        .CRIT_MASK(CRIT_BYTES)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .cfg_q   (cfg_word),
        .cfg_next(cfg_next),
        .crit_wr (crit_wr)
    );

    seq_phase_ctl #(.MW(MODE_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .crit_wr  (crit_wr),
        .next_mode(cfg_next[MODE_LSB +: MODE_W]),
        .sync_in  (sync_in),
        .cal_done (cal_finish),
        .cal_req  (cal_busy),
        .restart  (restart),
        .accept   (accept)
    );

    seq_out_guard #(.DW(DATA_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (res_valid && accept),
        .word_in(res_in),
        .reading(host_reading),
        .flush  (crit_wr || sync_in),
        .word_q (res_word),
        .rdy_n  (rdy_n)
    );

    // Mode field presented to the calibration engine.
    assign cal_kind = cfg_word[MODE_LSB +: MODE_W];
endmodule

// File: rtl/adc_conv_sequencer_chk.sv
// Port-level property checker for adc_conv_sequencer, attached by bind.
module adc_conv_sequencer_chk #(
    parameter int unsigned DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_be,
    input logic [23:0]   wr_data,
    input logic          sync_in,
    input logic          res_valid,
    input logic          host_reading,
    input logic [23:0]   cfg_word,
    input logic          cal_busy,
    input logic [2:0]    cal_kind,
    input logic          restart,
    input logic [DW-1:0] res_word,
    input logic          rdy_n
);
    logic crit;
    logic [2:0] mode_after;
    assign crit       = wr_en && (wr_be[2] || wr_be[1]);
    assign mode_after = wr_be[2] ? wr_data[23:21] : cal_kind;

    // R4: the ready flag falls only after an offered result.
    assert_ready_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(res_valid));

    // R2: no result reaches the holding register while calibrating.
    assert_cal_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && res_valid) |=> $stable(res_word));

    // R8: the held word is frozen during a protected read.
    assert_read_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_reading && !rdy_n) |=> $stable(res_word));

    // R5: a critical write withdraws ready and pulses restart.
    assert_crit_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crit |=> (rdy_n && restart));

    // R6: calibration follows the mode field after a critical write.
    assert_crit_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crit |=> (cal_busy == (mode_after != 3'b000)));

    // R7: a low-byte-only write leaves the upper bytes alone.
    assert_low_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 3'b001) |=>
        ($stable(cfg_word[23:8]) && cfg_word[7:0] == $past(wr_data[7:0])));

    // R10: sync withdraws ready and pulses restart.
    assert_sync_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (rdy_n && restart));
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(.DW(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .sync_in     (sync_in),
    .res_valid   (res_valid),
    .host_reading(host_reading),
    .cfg_word    (cfg_word),
    .cal_busy    (cal_busy),
    .cal_kind    (cal_kind),
    .restart     (restart),
    .res_word    (res_word),
    .rdy_n       (rdy_n)
);

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_be = '0;
    logic [23:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic        cal_finish = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_in = '0;
    logic        host_reading = 1'b0;
    logic [23:0] cfg_word;
    logic        cal_busy;
    logic [2:0]  cal_kind;
    logic        restart;
    logic [23:0] res_word;
    logic        rdy_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .sync_in(sync_in), .cal_finish(cal_finish),
        .res_valid(res_valid), .res_in(res_in), .host_reading(host_reading),
        .cfg_word(cfg_word), .cal_busy(cal_busy), .cal_kind(cal_kind),
        .restart(restart), .res_word(res_word), .rdy_n(rdy_n)
    );

    // {host_reading, result word}
    localparam logic [24:0] VEC [0:5] = '{
        {1'b0, 24'h111111}, {1'b0, 24'h7FFFFF}, {1'b1, 24'h800000},
        {1'b0, 24'h000001}, {1'b1, 24'hABCDEF}, {1'b1, 24'hFFFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_be = '0; sync_in = 0; cal_finish = 0; res_valid = 0;
    endtask

    initial begin
        logic [23:0] exp_word;
        logic        valid;
        step(); step(); step();
        rst_n = 1'b1;
        step();
        check("R1 cfg", {8'h0, cfg_word}, 32'h28B300);
        check("R1 rdy_n", {31'h0, rdy_n}, 1);
        check("R1 cal_busy", {31'h0, cal_busy}, 1);
        check("R1 cal_kind", {29'h0, cal_kind}, 1);

        // R2: result offered while calibrating is ignored
        res_valid = 1; res_in = 24'h555555;
        step(); idle();
        check("R2 rdy_n", {31'h0, rdy_n}, 1);
        check("R2 word", {8'h0, res_word}, 0);

        // R3: finish calibration
        cal_finish = 1;
        step(); idle();
        check("R3 cal_busy", {31'h0, cal_busy}, 0);

        // R3 R8 R9: table of results with and without reads
        exp_word = '0; valid = 0;
        for (int i = 0; i < 6; i++) begin
            logic dropped;
            host_reading = VEC[i][24]; res_in = VEC[i][23:0]; res_valid = 1;
            dropped = VEC[i][24] && valid;
            if (!dropped) begin exp_word = VEC[i][23:0]; valid = 1; end
            step();
            res_valid = 0;
            check("R3/R8 word", {8'h0, res_word}, {8'h0, exp_word});
            check("R3/R8 rdy_n", {31'h0, rdy_n}, 0);
            host_reading = 0;
            step();
            if (dropped) valid = 0;
            check("R9 rdy_n after read", {31'h0, rdy_n}, {31'h0, !valid});
        end

        // R7: low-byte-only write
        wr_en = 1; wr_be = 3'b001; wr_data = 24'hFFFFA5;
        step(); idle();
        check("R7 cfg", {8'h0, cfg_word}, 32'h28B3A5);
        check("R7 rdy_n", {31'h0, rdy_n}, 0);
        check("R7 restart", {31'h0, restart}, 0);
        check("R7 cal_busy", {31'h0, cal_busy}, 0);
        check("R7 word", {8'h0, res_word}, 32'hFFFFFF);

        // R5 R6: critical write with conversion mode 000
        wr_en = 1; wr_be = 3'b110; wr_data = 24'h1234FF;
        step(); idle();
        check("R5 rdy_n", {31'h0, rdy_n}, 1);
        check("R5 restart", {31'h0, restart}, 1);
        check("R6 no cal", {31'h0, cal_busy}, 0);
        check("R5 cfg", {8'h0, cfg_word}, 32'h1234A5);
        step();
        check("R5 restart one cycle", {31'h0, restart}, 0);
        res_valid = 1; res_in = 24'h0A0B0C;
        step(); idle();
        check("R3 load after resync", {8'h0, res_word}, 32'h0A0B0C);

        // R6: critical write into calibration mode 010 (byte 2 only)
        wr_en = 1; wr_be = 3'b100; wr_data = 24'h400000;
        step(); idle();
        check("R6 cal_busy", {31'h0, cal_busy}, 1);
        check("R6 cal_kind", {29'h0, cal_kind}, 2);

        // R10: sync during calibration does not end it
        sync_in = 1;
        step(); idle();
        check("R10 restart", {31'h0, restart}, 1);
        check("R10 cal kept", {31'h0, cal_busy}, 1);
        cal_finish = 1;
        step(); idle();
        res_valid = 1; res_in = 24'h123456;
        step(); idle();
        check("R3 load", {31'h0, rdy_n}, 0);

        // R10 R11: sync with a result in the same cycle drops it
        sync_in = 1; res_valid = 1; res_in = 24'h654321;
        step(); idle();
        check("R10 rdy_n", {31'h0, rdy_n}, 1);
        check("R11 sync over result", {8'h0, res_word}, 32'h123456);

        // R11: critical write over sync over result, mode 000
        wr_en = 1; wr_be = 3'b100; wr_data = 24'h000000;
        sync_in = 1; res_valid = 1; res_in = 24'h999999;
        step(); idle();
        check("R11 rdy_n", {31'h0, rdy_n}, 1);
        check("R11 word", {8'h0, res_word}, 32'h123456);
        check("R11 no cal", {31'h0, cal_busy}, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule